// File: doc/BRIEF.md
# Masked-Compare Periodic Interrupt Timer

The block is a free-running up-counter with a small word-addressed register window and one interrupt line. On every clock the counter is compared with a compare value. A mask register can exclude any bit position from that comparison, so a single compare value can stand for a whole group of counter values. When the comparison holds, a sticky interrupt flag is raised. Software clears the flag by writing a one to it.

A control bit selects clear-on-match. With it set, the counter returns to zero on the same clock edge that raises the flag, which gives a periodic interrupt whose period is set by the compare value. With it clear, the counter runs on past the match and wraps at its full range. A second control bit enables or freezes counting. Software can also load the counter directly, and such a load takes precedence over both counting and clear-on-match.

Accesses are single-cycle. A write is taken on the clock edge where the write enable is high. The read data is a combinational function of the address and shows the current register state.

Top module: `mcmp_timer`

## Requirements
- R1: Word-aligned offsets select the registers: 0x0 compare, 0x4 mask, 0x8 control, 0xC counter. The compare and mask registers read back exactly what was last written. An address with bit 1 or bit 0 set is ignored on write and reads as 0.
- R2: After reset, compare reads all ones, mask reads 0, counter reads 0, and control reads 0x08 (only the enable bit set).
- R3: While control bit 3 (enable) is 1, the counter rises by one per clock. While it is 0, the counter holds its value.
- R4: A match exists when, for every bit position, the counter bit equals the compare bit or the mask bit is 1.
- R5: Control bit 0 (flag) becomes 1 on the clock edge after any cycle that has a match, whether or not the counter is enabled. It stays 1 until software clears it. irq_o always equals the flag.
- R6: Writing the control register with bit 0 = 1 clears the flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: With control bit 1 (clear-on-match) at 1, a match loads 0 into the counter on the same edge that sets the flag. With it at 0, the counter keeps counting and wraps from all ones to 0.
- R8: If a match and a flag-clearing write fall in the same cycle, the flag ends up 1.
- R9: A write to the counter register loads the written value. It overrides the increment and the clear-on-match in that cycle.
- R10: Control bits other than 0, 1 and 3 read as 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of the register |
| we_i | input | 1 | Write enable, taken on the rising clock edge |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt level (flag bit) |

## Verification
The bench builds the block with DW = 8. At that width the full-range wrap and a periodic clear-on-match cycle both fit into a few hundred clocks, so both can be run in full rather than only near preloaded values. The 8-bit width also makes masked compares span many counter values, so a mask of 0x0F produces matches on a band of sixteen counts. A behavioural model updates alongside the design every clock, and the bench compares the interrupt and the addressed register after each edge. Directed moments, such as a clearing write that coincides with a match or a counter load on a match cycle, are arranged with the counter frozen or preloaded.

// File: rtl/mcmp_pkg.sv
package mcmp_pkg;
  typedef enum logic [1:0] {
    SEL_CMP  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_FLAG_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT  = 1;
  localparam int unsigned CTRL_EN_BIT   = 3;
endpackage

// File: rtl/mcmp_match.sv
module mcmp_match #(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] cmp_i,
  input  logic [DW-1:0] mask_i,
  output logic          match_o
);
  logic [DW-1:0] bit_ok;

  // R4: a set mask bit forces its position true
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign bit_ok[i] = mask_i[i] | (cnt_i[i] ~^ cmp_i[i]);
  end

  assign match_o = &bit_ok;
endmodule

// File: rtl/mcmp_counter.sv
module mcmp_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          match_i,
  input  logic          clr_on_match_i,
  input  logic          en_i,
  output logic [DW-1:0] cnt_o
);
  logic [DW-1:0] cnt_q;

  // priority: software load, clear-on-match, increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (wr_i)                       cnt_q <= wdata_i;
    else if (match_i && clr_on_match_i)  cnt_q <= '0;
    else if (en_i)                       cnt_q <= cnt_q + DW'(1);
  end

  assign cnt_o = cnt_q;

  // R9
  cnt_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wdata_i));

  // R3
  cnt_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(match_i && clr_on_match_i) && en_i) |=> cnt_q == $past(cnt_q) + DW'(1));

  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(match_i && clr_on_match_i) && !en_i) |=> $stable(cnt_q));

  // R7
  cnt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && match_i && clr_on_match_i) |=> cnt_q == '0);
endmodule

// File: rtl/mcmp_ctrl.sv
module mcmp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic flag_clr_i,
  input  logic clr_on_match_d_i,
  input  logic en_d_i,
  input  logic match_i,
  output logic flag_o,
  output logic clr_on_match_o,
  output logic en_o
);
  logic flag_q, clr_q, en_q;

  // set beats software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (match_i)             flag_q <= 1'b1;
    else if (wr_i && flag_clr_i)  flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clr_q <= 1'b0;
      en_q  <= 1'b1;
    end else if (wr_i) begin
      clr_q <= clr_on_match_d_i;
      en_q  <= en_d_i;
    end
  end

  assign flag_o         = flag_q;
  assign clr_on_match_o = clr_q;
  assign en_o           = en_q;

  // R5 R8
  flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_i |=> flag_q);

  // R6
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_i && flag_clr_i)) |=> flag_q);

  // R6
  flag_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!match_i && wr_i && flag_clr_i) |=> !flag_q);
endmodule

// File: rtl/mcmp_timer.sv
module mcmp_timer
  import mcmp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  reg_sel_e      sel;
  logic          hit;
  logic          wr_cmp, wr_mask, wr_ctrl, wr_cnt;
  logic [DW-1:0] cmp_q, mask_q, cnt;
  logic [DW-1:0] ctrl_word;
  logic          match, flag, clr_on_match, en;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign hit     = (addr_i[1:0] == 2'b00);
  assign wr_cmp  = we_i && hit && (sel == SEL_CMP);
  assign wr_mask = we_i && hit && (sel == SEL_MASK);
  assign wr_ctrl = we_i && hit && (sel == SEL_CTRL);
  assign wr_cnt  = we_i && hit && (sel == SEL_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q  <= '1;
      mask_q <= '0;
    end else begin
      if (wr_cmp)  cmp_q  <= wdata_i;
      if (wr_mask) mask_q <= wdata_i;
    end
  end

  mcmp_match #(.DW(DW)) u_match (
    .cnt_i   (cnt),
    .cmp_i   (cmp_q),
    .mask_i  (mask_q),
    .match_o (match)
  );

  mcmp_ctrl u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_i             (wr_ctrl),
    .flag_clr_i       (wdata_i[CTRL_FLAG_BIT]),
    .clr_on_match_d_i (wdata_i[CTRL_CLR_BIT]),
    .en_d_i           (wdata_i[CTRL_EN_BIT]),
    .match_i          (match),
    .flag_o           (flag),
    .clr_on_match_o   (clr_on_match),
    .en_o             (en)
  );

  mcmp_counter #(.DW(DW)) u_cnt (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_i           (wr_cnt),
    .wdata_i        (wdata_i),
    .match_i        (match),
    .clr_on_match_i (clr_on_match),
    .en_i           (en),
    .cnt_o          (cnt)
  );

  always_comb begin
    ctrl_word                = '0;
    ctrl_word[CTRL_FLAG_BIT] = flag;
    ctrl_word[CTRL_CLR_BIT]  = clr_on_match;
    ctrl_word[CTRL_EN_BIT]   = en;
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      unique case (sel)
        SEL_CMP:  rdata_o = cmp_q;
        SEL_MASK: rdata_o = mask_q;
        SEL_CTRL: rdata_o = ctrl_word;
        SEL_CNT:  rdata_o = cnt;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign irq_o = flag;

  // R10
  ctrl_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && sel == SEL_CTRL) |-> (rdata_o & ~DW'(32'hB)) == '0);

  // R5
  irq_lvl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(match));
endmodule

// File: tb/sim_mcmp_timer.sv
`timescale 1ns/1ps
module sim_mcmp_timer;
  localparam int unsigned DW = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [3:0]    addr_i = '0;
  logic          we_i = 1'b0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_cmp = '1, m_mask = '0, m_cnt = '0;
  logic          m_flag = 1'b0, m_clr = 1'b0, m_en = 1'b1;

  always #2.5 clk_i = ~clk_i;

  mcmp_timer #(.DW(DW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [DW-1:0] exp_read(input logic [3:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[3:2])
      2'd0: return m_cmp;
      2'd1: return m_mask;
      2'd2: return DW'({m_en, 1'b0, m_clr, m_flag});
      default: return m_cnt;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, advance model, compare at next negedge
  task automatic step(input logic [3:0] a, input logic we, input logic [DW-1:0] d, input string req);
    logic match;
    logic hit;
    logic [DW-1:0] n_cnt;
    logic n_flag;
    addr_i = a; we_i = we; wdata_i = d;
    hit = (a[1:0] == 2'b00);
    match = 1'b1;
    for (int i = 0; i < DW; i++)
      if (!m_mask[i] && (m_cnt[i] != m_cmp[i])) match = 1'b0;
    n_flag = m_flag;
    if (we && hit && a[3:2] == 2'd2 && d[0]) n_flag = 1'b0;
    if (match) n_flag = 1'b1;
    if (we && hit && a[3:2] == 2'd3)  n_cnt = d;
    else if (match && m_clr)          n_cnt = '0;
    else if (m_en)                    n_cnt = m_cnt + 8'd1;
    else                              n_cnt = m_cnt;
    @(negedge clk_i);
    if (we && hit) begin
      case (a[3:2])
        2'd0: m_cmp = d;
        2'd1: m_mask = d;
        2'd2: begin m_clr = d[1]; m_en = d[3]; end
        default: ;
      endcase
    end
    m_cnt = n_cnt;
    m_flag = n_flag;
    check({req, " irq"}, DW'(irq_o), DW'(m_flag));
    check({req, " rd"}, rdata_o, exp_read(a));
  endtask

  task automatic idle(input logic [3:0] a, input int n, input string req);
    for (int i = 0; i < n; i++) step(a, 1'b0, '0, req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R2 reset values, read while reset is held
    #3;
    for (int r = 0; r < 4; r++) begin
      addr_i = 4'(r * 4);
      #1;
      check("R2 reset", rdata_o, exp_read(addr_i));
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    idle(4'hC, 5, "R3 count");
    // R1 register map
    step(4'h0, 1'b1, 8'h40, "R1 cmp wr");
    step(4'h0, 1'b0, 8'h00, "R1 cmp rd");
    step(4'h4, 1'b1, 8'h00, "R1 mask wr");
    step(4'h1, 1'b1, 8'h77, "R1 unaligned");
    step(4'h0, 1'b0, 8'h00, "R1 cmp kept");
    // R3 hold when disabled
    step(4'h8, 1'b1, 8'h00, "R3 disable");
    idle(4'hC, 4, "R3 hold");
    step(4'h8, 1'b1, 8'h08, "R3 enable");
    // R9 load, R5 flag at match
    step(4'hC, 1'b1, 8'h3C, "R9 load");
    idle(4'h8, 8, "R5 flag");
    // R6 write zero keeps, write one clears
    step(4'h8, 1'b1, 8'h08, "R6 keep");
    step(4'h8, 1'b1, 8'h09, "R6 clear");
    // R4 R7 masked periodic clear
    step(4'h4, 1'b1, 8'h0F, "R4 mask");
    step(4'h8, 1'b1, 8'h0B, "R7 clr on");
    idle(4'hC, 150, "R7 periodic");
    idle(4'h8, 20, "R4 band");
    // R8 set wins over clear
    step(4'h8, 1'b1, 8'h01, "R8 freeze");
    step(4'hC, 1'b1, 8'h45, "R8 park");
    step(4'h8, 1'b1, 8'h01, "R8 race");
    check("R8 flag", DW'(irq_o), 8'h01);
    step(4'h4, 1'b1, 8'h00, "R6 unmask");
    step(4'hC, 1'b1, 8'h00, "R6 move");
    step(4'h8, 1'b1, 8'h01, "R6 clear2");
    check("R6 flag", DW'(irq_o), 8'h00);
    // R9 load beats clear-on-match
    step(4'h8, 1'b1, 8'h0A, "R9 clr on");
    step(4'hC, 1'b1, 8'h40, "R9 to match");
    step(4'hC, 1'b1, 8'h20, "R9 beats clr");
    check("R9 value", rdata_o, 8'h20);
    // R7 wrap with clear-on-match off
    step(4'h0, 1'b1, 8'h10, "R7 cmp");
    step(4'h8, 1'b1, 8'h09, "R7 clr off");
    step(4'hC, 1'b1, 8'hFD, "R7 near top");
    idle(4'hC, 5, "R7 wrap");
    // R10 reserved control bits
    step(4'h8, 1'b1, 8'hF6, "R10 rsvd");
    step(4'h8, 1'b1, 8'hFF, "R10 rsvd2");
    check("R10 mask", rdata_o & 8'hF4, 8'h00);
    step(4'h9, 1'b0, 8'h00, "R1 unaligned rd");
    // long run through full-range wrap
    step(4'h8, 1'b1, 8'h09, "R3 run");
    idle(4'hC, 300, "R3 long");

    we_i = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule